// File: doc/BRIEF.md
# Write-Back Two-Way Set-Associative Cache Level

This block is one level of a data cache hierarchy. It is two-way set associative and uses a write-back policy. A requester above it issues loads and stores through a ready/valid handshake. A block-wide port below it talks to the next lower level, and uses that port only to fetch missing lines and to push out modified lines that are being evicted.

Each way of each set holds four things: a valid flag, a dirty flag, a tag and one data block. Each set also holds an age bit that names the way to replace next. A store changes only this level and marks the line modified. The lower level sees that data only when the line is evicted. At that point the whole block moves down exactly one level, and a write transaction downstream tells that level to keep the block as modified. The geometry (address width, number of sets, block size) is set by parameters.

Top module: `wbTwoWayCache`

## Requirements
- R1: After reset, every way of every set is invalid and clean. While idle, `reqReady` is 1 and both `respValid` and `memReqValid` are 0. A line that was never stored to is never written downstream.
- R2: An address splits, from the least significant bit up, into a block offset of log2(BLOCK_BYTES) bits, a set index of log2(NUM_SETS) bits, and a tag in the remaining upper bits. Every downstream request carries the block address, which is the tag and index concatenated, i.e. the address shifted right by the offset width.
- R3: On a hit, `respValid` is 1 in the cycle after the request is accepted and lasts one cycle. `reqReady` is 0 in that cycle and returns to 1 in the next cycle.
- R4: On a miss, `respValid` stays 0 and `reqReady` stays 0 until the fill, and any write-back before it, has been acknowledged. Exactly one downstream read of the request's block is made. `respValid` rises in the cycle after the fill is acknowledged.
- R5: A store that hits changes only this level and makes no downstream transaction. Later loads return the stored bytes.
- R6: `reqSize` selects the access width: 0 is one byte, 1 is two bytes, and 2 or 3 is four bytes. Accesses are naturally aligned within the block. A store writes only the selected bytes, taken from the low bytes of `reqWdata`. A load returns the selected bytes right-aligned in `respRdata`, with the upper bits zero.
- R7: On a miss, an invalid way of the set is filled before any valid way is evicted, and way 0 is filled before way 1.
- R8: When both ways are valid, the victim is the way not accessed most recently. Every hit, whether load or store, makes the other way of that set the next victim.
- R9: When the victim is dirty, a single downstream write (`memReqWrite` = 1) of the victim's block address and full block data comes before the fill read. That write tells the lower level to hold the block as modified.
- R10: A clean victim is dropped without any downstream write.
- R11: A store miss allocates a line, fetches the block, merges the store bytes into it and leaves the line dirty.
- R12: A downstream request keeps `memReqValid`, `memReqWrite` and `memReqAddr` steady until the cycle in which `memAck` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Cache can accept a request |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 32 | Store data, low bytes used |
| reqSize | input | 2 | Access width code |
| respValid | output | 1 | Access complete (one-cycle pulse) |
| respRdata | output | 32 | Load data, valid with respValid |
| memReqValid | output | 1 | Downstream request present |
| memReqWrite | output | 1 | 1 = write-back of a modified block, 0 = fill read |
| memReqAddr | output | ADDR_W-log2(BLOCK_BYTES) | Block address |
| memWdata | output | 8*BLOCK_BYTES | Block being written back |
| memAck | input | 1 | Lower level completes the current request |
| memRdata | input | 8*BLOCK_BYTES | Fill data, valid with memAck on a read |

## Verification
A hit is due one cycle after acceptance. A miss completes one cycle after the fill acknowledge, and a dirty eviction puts its write acknowledge before that fill. The bench drives each request at a falling edge and checks for the hit pulse exactly one falling edge after the accepting rising edge. On a predicted miss it then waits edge by edge for the response, confirming that `reqReady` stays low throughout. The downstream responder acknowledges after a random delay and logs each transaction. After every access the bench compares that log with the write-back and fill a reference model predicts, so the results do not depend on the delay.

// File: rtl/wbCachePkg.sv
package wbCachePkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL
  } cacheStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch the incoming request
    logic hitUpdate;   // hit: refresh age bit, merge store data
    logic pickVictim;  // miss: remember the chosen way
    logic fillLine;    // write fetched block into the victim way
    logic selWb;       // downstream address comes from the victim
  } cacheStrobeT;

  function automatic int sizeBytes(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/wbCacheWay.sv
module wbCacheWay #(
  parameter int NUM_SETS = 4,
  parameter int IDX_W    = 2,
  parameter int TAG_W    = 7,
  parameter int BLK_W    = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] idx,
  output logic             rdValid,
  output logic             rdDirty,
  output logic [TAG_W-1:0] rdTag,
  output logic [BLK_W-1:0] rdData,
  input  logic             wrEn,
  input  logic             wrDirty,
  input  logic [TAG_W-1:0] wrTag,
  input  logic [BLK_W-1:0] wrData
);

  logic [NUM_SETS-1:0] validQ;
  logic [NUM_SETS-1:0] dirtyQ;
  logic [TAG_W-1:0]    tagQ  [NUM_SETS];
  logic [BLK_W-1:0]    dataQ [NUM_SETS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else if (wrEn) begin
      validQ[idx] <= 1'b1;
      dirtyQ[idx] <= wrDirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      tagQ[idx]  <= wrTag;
      dataQ[idx] <= wrData;
    end
  end

  assign rdValid = validQ[idx];
  assign rdDirty = dirtyQ[idx];
  assign rdTag   = tagQ[idx];
  assign rdData  = dataQ[idx];

endmodule

// File: rtl/wbCacheCtrl.sv
module wbCacheCtrl
  import wbCachePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        respValid,
  input  logic        hit,
  input  logic        victimDirty,
  output logic        memReqValid,
  output logic        memReqWrite,
  input  logic        memAck,
  output cacheStrobeT strobe
);

  cacheStateT stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    strobe      = '0;
    reqReady    = 1'b0;
    respValid   = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateD         = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          respValid        = 1'b1;
          strobe.hitUpdate = 1'b1;
          stateD           = ST_IDLE;
        end else begin
          strobe.pickVictim = 1'b1;
          stateD            = victimDirty ? ST_WBACK : ST_FILL;
        end
      end
      ST_WBACK: begin
        memReqValid  = 1'b1;
        memReqWrite  = 1'b1;
        strobe.selWb = 1'b1;
        if (memAck) stateD = ST_FILL;
      end
      ST_FILL: begin
        memReqValid = 1'b1;
        if (memAck) begin
          strobe.fillLine = 1'b1;
          stateD          = ST_LOOKUP;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/wbCacheDatapath.sv
module wbCacheDatapath
  import wbCachePkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_SETS    = 4,
  parameter int BLOCK_BYTES = 8,
  localparam int OFF_W   = $clog2(BLOCK_BYTES),
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int BLK_W   = 8 * BLOCK_BYTES,
  localparam int MADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  cacheStrobeT        strobe,
  input  logic               reqStore,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [WORD_W-1:0]  reqWdata,
  input  logic [1:0]         reqSize,
  output logic               hit,
  output logic               victimDirty,
  output logic [WORD_W-1:0]  respRdata,
  output logic [MADDR_W-1:0] memReqAddr,
  output logic [BLK_W-1:0]   memWdata,
  input  logic [BLK_W-1:0]   memRdata
);

  logic              sStore;
  logic [ADDR_W-1:0] sAddr;
  logic [WORD_W-1:0] sWdata;
  logic [1:0]        sSize;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sStore <= 1'b0;
      sAddr  <= '0;
      sWdata <= '0;
      sSize  <= '0;
    end else if (strobe.capture) begin
      sStore <= reqStore;
      sAddr  <= reqAddr;
      sWdata <= reqWdata;
      sSize  <= reqSize;
    end
  end

  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tagIn;
  assign off   = sAddr[OFF_W-1:0];
  assign idx   = sAddr[OFF_W +: IDX_W];
  assign tagIn = sAddr[ADDR_W-1 -: TAG_W];

  logic             wayValid [2];
  logic             wayDirty [2];
  logic [TAG_W-1:0] wayTag   [2];
  logic [BLK_W-1:0] wayData  [2];
  logic [1:0]       wayWrEn;
  logic [1:0]       hitVec;
  logic             wrDirty;
  logic [BLK_W-1:0] wrData;
  logic [BLK_W-1:0] mergedBlk;
  logic [BLK_W-1:0] hitData;
  logic [NUM_SETS-1:0] lruQ;  // per set: way to evict next
  logic             victimQ;
  logic             victimNow;

  for (genvar w = 0; w < 2; w++) begin : g_way
    wbCacheWay #(
      .NUM_SETS(NUM_SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_W(BLK_W)
    ) u_way (
      .clk    (clk),
      .rstN   (rstN),
      .idx    (idx),
      .rdValid(wayValid[w]),
      .rdDirty(wayDirty[w]),
      .rdTag  (wayTag[w]),
      .rdData (wayData[w]),
      .wrEn   (wayWrEn[w]),
      .wrDirty(wrDirty),
      .wrTag  (tagIn),
      .wrData (wrData)
    );
    assign hitVec[w]  = wayValid[w] && (wayTag[w] == tagIn);
    assign wayWrEn[w] = (strobe.hitUpdate && sStore && hitVec[w]) ||
                        (strobe.fillLine && (victimQ == 1'(w)));
  end

  assign hit     = |hitVec;
  assign hitData = hitVec[1] ? wayData[1] : wayData[0];

  // invalid ways first (way 0 before way 1), then the older way
  assign victimNow   = !wayValid[0] ? 1'b0 : (!wayValid[1] ? 1'b1 : lruQ[idx]);
  assign victimDirty = wayValid[victimNow] && wayDirty[victimNow];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      victimQ <= 1'b0;
      lruQ    <= '0;
    end else begin
      if (strobe.pickVictim) victimQ <= victimNow;
      if (strobe.hitUpdate)  lruQ[idx] <= ~hitVec[1];
    end
  end

  always_comb begin
    int nb;
    nb        = sizeBytes(sSize);
    mergedBlk = hitData;
    for (int b = 0; b < BLOCK_BYTES; b++) begin
      if (b >= int'(off) && b < int'(off) + nb)
        mergedBlk[8*b +: 8] = 8'(sWdata >> (8 * (b - int'(off))));
    end
  end

  assign wrDirty = strobe.hitUpdate;
  assign wrData  = strobe.fillLine ? memRdata : mergedBlk;

  always_comb begin
    logic [BLK_W-1:0]  shiftedBlk;
    logic [WORD_W-1:0] loadMask;
    shiftedBlk = hitData >> {off, 3'b000};
    case (sSize)
      2'd0:    loadMask = 32'h0000_00FF;
      2'd1:    loadMask = 32'h0000_FFFF;
      default: loadMask = 32'hFFFF_FFFF;
    endcase
    respRdata = shiftedBlk[WORD_W-1:0] & loadMask;
  end

  assign memReqAddr = strobe.selWb ? {wayTag[victimQ], idx} : {tagIn, idx};
  assign memWdata   = wayData[victimQ];

endmodule

// File: rtl/wbTwoWayCache.sv
module wbTwoWayCache
  import wbCachePkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_SETS    = 4,
  parameter int BLOCK_BYTES = 8,
  localparam int OFF_W   = $clog2(BLOCK_BYTES),
  localparam int BLK_W   = 8 * BLOCK_BYTES,
  localparam int MADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqStore,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [WORD_W-1:0]  reqWdata,
  input  logic [1:0]         reqSize,
  output logic               respValid,
  output logic [WORD_W-1:0]  respRdata,
  output logic               memReqValid,
  output logic               memReqWrite,
  output logic [MADDR_W-1:0] memReqAddr,
  output logic [BLK_W-1:0]   memWdata,
  input  logic               memAck,
  input  logic [BLK_W-1:0]   memRdata
);

  cacheStrobeT strobe;
  logic        hit;
  logic        victimDirty;

  wbCacheCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .respValid  (respValid),
    .hit        (hit),
    .victimDirty(victimDirty),
    .memReqValid(memReqValid),
    .memReqWrite(memReqWrite),
    .memAck     (memAck),
    .strobe     (strobe)
  );

  wbCacheDatapath #(
    .ADDR_W(ADDR_W), .NUM_SETS(NUM_SETS), .BLOCK_BYTES(BLOCK_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqStore   (reqStore),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .reqSize    (reqSize),
    .hit        (hit),
    .victimDirty(victimDirty),
    .respRdata  (respRdata),
    .memReqAddr (memReqAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata)
  );

endmodule

// File: rtl/wbCacheChecker.sv
module wbCacheChecker #(
  parameter int MADDR_W = 9
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic               respValid,
  input logic               memReqValid,
  input logic               memReqWrite,
  input logic               memAck,
  input logic [MADDR_W-1:0] memReqAddr
);

  // R3: the cycle after acceptance is never another accept slot
  p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R3: response is a single-cycle pulse
  p_resp_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  // R4: two cycles after acceptance the cache is either idle again or fetching
  p_settle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> ##1 (reqReady || memReqValid));

  // R4: upstream stalls while a downstream transaction is open
  p_stall_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (!reqReady && !respValid));

  // R4: response follows an acknowledged fill by one cycle
  p_fill_resp_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqWrite && memAck) |=> respValid);

  // R9: an acknowledged write-back is followed by the fill read
  p_wb_then_fill_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite && memAck) |=> (memReqValid && !memReqWrite));

  // R12: request held steady until acknowledged
  p_hold_req_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memAck) |=>
      (memReqValid && $stable(memReqWrite) && $stable(memReqAddr)));

endmodule

bind wbTwoWayCache wbCacheChecker #(.MADDR_W(MADDR_W)) u_chk (.*);

// File: tb/wbTwoWayCache_test.sv
module wbTwoWayCache_test;

  localparam int ADDR_W  = 12;
  localparam int SETS    = 4;
  localparam int BB      = 8;
  localparam int OFF_W   = 3;
  localparam int IDX_W   = 2;
  localparam int TAG_W   = 7;
  localparam int BLK_W   = 64;
  localparam int MADDR_W = 9;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               reqValid = 1'b0;
  logic               reqReady;
  logic               reqStore = 1'b0;
  logic [ADDR_W-1:0]  reqAddr = '0;
  logic [31:0]        reqWdata = '0;
  logic [1:0]         reqSize = '0;
  logic               respValid;
  logic [31:0]        respRdata;
  logic               memReqValid;
  logic               memReqWrite;
  logic [MADDR_W-1:0] memReqAddr;
  logic [BLK_W-1:0]   memWdata;
  logic               memAck = 1'b0;
  logic [BLK_W-1:0]   memRdata = '0;

  always #2 clk = ~clk;

  wbTwoWayCache #(.ADDR_W(ADDR_W), .NUM_SETS(SETS), .BLOCK_BYTES(BB)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqStore(reqStore), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqSize(reqSize),
    .respValid(respValid), .respRdata(respRdata), .memReqValid(memReqValid),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  // lower level (responder) state and log
  logic [BLK_W-1:0] lowerMem   [512];
  bit               lowerDirty [512];
  int               wrCount = 0;
  int               rdCount = 0;
  logic [MADDR_W-1:0] lastWrAddr, lastRdAddr;
  logic [BLK_W-1:0]   lastWrData;

  // reference model
  logic [BLK_W-1:0] refMem [512];
  bit               mValid [SETS][2];
  bit               mDirty [SETS][2];
  logic [TAG_W-1:0] mTag   [SETS][2];
  logic [BLK_W-1:0] mData  [SETS][2];
  bit               mLru   [SETS];

  function automatic logic [BLK_W-1:0] garbage(input int b);
    return {32'hA500_0000 ^ (b * 32'h9E37), 32'h00C0_FFEE + b};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int nBytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  // responder: acknowledges after a random delay, logs each transaction
  initial begin
    int delay;
    delay = 0;
    for (int b = 0; b < 512; b++) begin
      lowerMem[b] = garbage(b);
      lowerDirty[b] = 0;
    end
    forever begin
      @(negedge clk);
      memAck = 1'b0;
      if (rstN && memReqValid) begin
        if (delay == 0) begin
          memAck = 1'b1;
          if (memReqWrite) begin
            lowerMem[memReqAddr] = memWdata;
            lowerDirty[memReqAddr] = 1;
            lastWrAddr = memReqAddr;
            lastWrData = memWdata;
            wrCount++;
          end else begin
            memRdata = lowerMem[memReqAddr];
            lastRdAddr = memReqAddr;
            rdCount++;
          end
          delay = $urandom % 4;
        end else begin
          delay--;
        end
      end
    end
  end

  task automatic access(input bit st, input logic [ADDR_W-1:0] a,
                        input logic [31:0] wd, input logic [1:0] sz);
    int idx, off, n, w, wrBefore, rdBefore, waitCnt;
    logic [TAG_W-1:0] tg;
    bit expHit, expWb, stallOk;
    logic [MADDR_W-1:0] expWbAddr;
    logic [BLK_W-1:0] expWbData;
    logic [31:0] expLoad;
    off = int'(a[OFF_W-1:0]);
    idx = int'(a[OFF_W +: IDX_W]);
    tg  = a[ADDR_W-1 -: TAG_W];
    n   = nBytes(sz);
    expWb = 0; expWbAddr = '0; expWbData = '0; expLoad = '0;
    expHit = 0; w = 0;
    for (int k = 0; k < 2; k++)
      if (mValid[idx][k] && mTag[idx][k] == tg) begin expHit = 1; w = k; end
    if (!expHit) begin
      w = !mValid[idx][0] ? 0 : (!mValid[idx][1] ? 1 : int'(mLru[idx]));
      if (mValid[idx][w] && mDirty[idx][w]) begin
        expWb = 1;
        expWbAddr = {mTag[idx][w], IDX_W'(idx)};
        expWbData = mData[idx][w];
        refMem[expWbAddr] = expWbData;
      end
      mData[idx][w]  = refMem[{tg, IDX_W'(idx)}];
      mTag[idx][w]   = tg;
      mValid[idx][w] = 1;
      mDirty[idx][w] = 0;
    end
    mLru[idx] = (w == 0);
    if (st) begin
      for (int k = 0; k < n; k++) mData[idx][w][(off + k) * 8 +: 8] = wd[k * 8 +: 8];
      mDirty[idx][w] = 1;
    end else begin
      for (int k = 0; k < n; k++) expLoad[k * 8 +: 8] = mData[idx][w][(off + k) * 8 +: 8];
    end

    @(negedge clk);
    check(reqReady == 1'b1, "R3", "ready before request", 64'(reqReady), 64'd1);
    reqValid = 1'b1; reqStore = st; reqAddr = a; reqWdata = wd; reqSize = sz;
    wrBefore = wrCount; rdBefore = rdCount;
    @(negedge clk);
    reqValid = 1'b0;
    if (expHit) begin
      check(respValid == 1'b1, "R3", "hit response one cycle after accept", 64'(respValid), 64'd1);
      check(reqReady == 1'b0, "R3", "ready low in response cycle", 64'(reqReady), 64'd0);
    end else begin
      check(respValid == 1'b0, "R4", "no response in lookup of a miss", 64'(respValid), 64'd0);
      stallOk = 1; waitCnt = 0;
      while (!respValid && waitCnt < 100) begin
        if (reqReady) stallOk = 0;
        @(negedge clk);
        waitCnt++;
      end
      check(stallOk, "R4", "ready held low during miss", 64'(stallOk), 64'd1);
      check(respValid == 1'b1, "R4", "miss eventually responds", 64'(respValid), 64'd1);
    end
    if (expWb) begin
      check(wrCount - wrBefore == 1, "R9", "write-back count", 64'(wrCount - wrBefore), 64'd1);
      check(lastWrAddr == expWbAddr, "R9", "write-back block address", 64'(lastWrAddr), 64'(expWbAddr));
      check(lastWrData == expWbData, "R9", "write-back data", lastWrData, expWbData);
      check(lowerDirty[expWbAddr], "R9", "lower level holds block as modified", 64'(lowerDirty[expWbAddr]), 64'd1);
    end else begin
      check(wrCount == wrBefore, expHit ? "R5" : "R10", "no downstream write", 64'(wrCount - wrBefore), 64'd0);
    end
    if (expHit) begin
      check(rdCount == rdBefore, "R5", "hit makes no fill", 64'(rdCount - rdBefore), 64'd0);
    end else begin
      check(rdCount - rdBefore == 1, "R4", "one fill read", 64'(rdCount - rdBefore), 64'd1);
      check(lastRdAddr == {tg, IDX_W'(idx)}, "R2", "fill block address", 64'(lastRdAddr), 64'({tg, IDX_W'(idx)}));
    end
    if (!st)
      check(respRdata == expLoad, "R6", "load data", 64'(respRdata), 64'(expLoad));
  endtask

  function automatic logic [ADDR_W-1:0] mkAddr(input int tg, input int idx, input int off);
    return {TAG_W'(tg), IDX_W'(idx), OFF_W'(off)};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < 512; b++) refMem[b] = garbage(b);
    for (int s = 0; s < SETS; s++) begin
      mLru[s] = 0;
      for (int k = 0; k < 2; k++) begin
        mValid[s][k] = 0; mDirty[s][k] = 0; mTag[s][k] = '0; mData[s][k] = '0;
      end
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(reqReady == 1'b1, "R1", "ready after reset", 64'(reqReady), 64'd1);
    check(respValid == 1'b0, "R1", "no response after reset", 64'(respValid), 64'd0);
    check(memReqValid == 1'b0, "R1", "no downstream request in reset", 64'(memReqValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(memReqValid == 1'b0, "R1", "idle after reset", 64'(memReqValid), 64'd0);

    // directed: set 0
    access(0, mkAddr(1, 0, 4), 32'h0, 2'd2);           // R1/R4 cold miss, no write-back
    access(0, mkAddr(1, 0, 0), 32'h0, 2'd2);           // R3 hit
    access(1, mkAddr(2, 0, 3), 32'h0000_00C3, 2'd0);   // R7 R11 store miss into way 1
    access(0, mkAddr(2, 0, 0), 32'h0, 2'd2);           // R6 merged byte visible
    access(0, mkAddr(1, 0, 0), 32'h0, 2'd1);           // R8 touch way 0
    access(0, mkAddr(3, 0, 0), 32'h0, 2'd2);           // R8 R9 evicts dirty tag 2
    access(1, mkAddr(1, 0, 6), 32'h0000_BEEF, 2'd1);   // R5 store hit, no txn
    access(0, mkAddr(1, 0, 4), 32'h0, 2'd2);           // R5 R6 read back halfword
    access(0, mkAddr(3, 0, 0), 32'h0, 2'd2);           // R8 touch tag 3
    access(0, mkAddr(4, 0, 0), 32'h0, 2'd2);           // R9 evicts dirty tag 1
    access(0, mkAddr(5, 0, 0), 32'h0, 2'd2);           // R10 evicts clean tag 3
    access(0, mkAddr(2, 0, 0), 32'h0, 2'd2);           // R9 data came back from lower level
    access(1, mkAddr(6, 3, 4), 32'h1234_5678, 2'd3);   // R6 size 3 means four bytes
    access(0, mkAddr(6, 3, 4), 32'h0, 2'd2);

    // random phase
    for (int i = 0; i < 400; i++) begin
      int sz, off;
      sz  = $urandom % 4;
      off = ($urandom % BB) & ~(nBytes(2'(sz)) - 1);
      access(1'($urandom % 2), mkAddr($urandom % 6, $urandom % SETS, off),
             $urandom, 2'(sz));
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

endmodule